// File: doc/BRIEF.md
# DMA Channel Register File with Interrupts

This block is the software-facing register slave of a single-channel DMA engine. A processor programs the transfer through simple single-beat reads and writes in a 64-byte window. It sets the source address, the destination address, and whether each address steps or stays fixed. It then writes the byte count. That last write produces a one-cycle start pulse toward the engine. The engine reports back its busy level, its done and error pulses, and its live source, destination and remaining-length values.

While a transfer runs, the address and length registers read back the engine's live progress and cannot be rewritten. When busy drops, the final live values are latched, so software sees where the transfer stopped. A status word shows busy and a sticky bus-error flag. An interrupt-status word records done and error events, and its bits are toggled by writing ones. Together with an enable word, it drives one level interrupt. A magic write to the reset word restores every register and pulses a reset toward the engine. Partial-word accesses, misaligned accesses and wrong reset keys are answered with a bus error.

Top module: `dma_regfile`

## Requirements
- R1: After reset the control word (offset 0x04) reads 0x80000000, meaning source stepping on (bit 31) and destination stepping off (bit 30). Source (0x08), destination (0x0C), length (0x10), status (0x14), interrupt status (0x2C) and interrupt enable (0x30) all read 0, and `irq` is low.
- R2: Every request is answered by `bus_ack` one cycle later, with `bus_rdata` valid in the same cycle. Written registers read back at their offsets. Any offset not listed in R1, and the reset word at 0x00, reads 0. Writes to unlisted offsets change nothing.
- R3: Writing 0x0000000A to offset 0x00 returns every register to its R1 value and pulses `eng_srst` for one cycle without an error. Writing any other value there gives `bus_err` and changes nothing.
- R4: An access with `bus_be` other than all ones, or with `bus_addr[1:0]` nonzero, gives `bus_err`, returns 0 and writes nothing.
- R5: A length write while `eng_busy` is low updates `cfg_len` and raises `eng_start` for exactly one cycle, in the same cycle as the `bus_ack` of that write.
- R6: While `eng_busy` is high, source, destination and length read the `live_*` inputs. Writes to them are ignored: `cfg_*` keeps its value and no `eng_start` is produced.
- R7: On the cycle after `eng_busy` falls, the source, destination and length registers hold the `live_*` values present when it fell.
- R8: Status bit 31 shows `eng_busy`. Status bit 30 is set by an `eng_err` pulse and stays set until the next accepted start. Writes to the status word have no effect.
- R9: Interrupt-status bit 0 is set by `eng_done` and bit 1 by `eng_err`. Writing a 1 to a bit position toggles that bit, and writing a 0 leaves it alone.
- R10: If an event pulse and a toggle write hit the same interrupt-status bit in the same cycle, the bit ends up set.
- R11: `irq` is high exactly when some interrupt-status bit and the matching enable bit (same position as R9) are both 1. A clear enable does not stop the status bit from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Single-beat access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte offset inside the register window |
| bus_be | input | DATA_W/8 (4) | Byte enables; all ones required |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_ack | output | 1 | Response, one cycle after the request |
| bus_err | output | 1 | Error flag qualifying `bus_ack` |
| bus_rdata | output | DATA_W (32) | Read data, valid with `bus_ack` |
| cfg_src_inc | output | 1 | Source address steps per transfer |
| cfg_dst_inc | output | 1 | Destination address steps per transfer |
| cfg_src_addr | output | DATA_W (32) | Programmed source address |
| cfg_dst_addr | output | DATA_W (32) | Programmed destination address |
| cfg_len | output | DATA_W (32) | Programmed byte count |
| eng_start | output | 1 | One-cycle start pulse |
| eng_srst | output | 1 | One-cycle software reset pulse toward the engine |
| eng_busy | input | 1 | Engine transfer in progress |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine bus-error pulse |
| live_src_addr | input | DATA_W (32) | Engine's current source address |
| live_dst_addr | input | DATA_W (32) | Engine's current destination address |
| live_len | input | DATA_W (32) | Engine's remaining byte count |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume `eng_done` and `eng_err` are single-cycle pulses. They also assume the engine holds its `live_*` values steady in the cycle `eng_busy` falls, and that a request is a one-cycle strobe. The bench drives every bus and engine input at the falling clock edge. It raises each request for exactly one cycle. It changes the live values only while busy is high or before busy drops. It pulses the event inputs for one cycle, including the case where a pulse coincides with a toggle write.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SRST,
    SEL_CTRL,
    SEL_SRC,
    SEL_DST,
    SEL_LEN,
    SEL_STAT,
    SEL_ISR,
    SEL_IER
  } reg_sel_e;

  localparam logic [7:0] OFF_SRST = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h04;
  localparam logic [7:0] OFF_SRC  = 8'h08;
  localparam logic [7:0] OFF_DST  = 8'h0C;
  localparam logic [7:0] OFF_LEN  = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h14;
  localparam logic [7:0] OFF_ISR  = 8'h2C;
  localparam logic [7:0] OFF_IER  = 8'h30;

  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  // event slots inside the interrupt words
  localparam int unsigned EVT_DONE = 0;
  localparam int unsigned EVT_ERR  = 1;
  localparam int unsigned N_EVT    = 2;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W/8-1:0]   be,
  input  logic [DATA_W-1:0]     wdata,
  output reg_sel_e              sel,
  output logic                  bad,
  output logic                  wr_ok,
  output logic                  soft_hit
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic [7:0] off_w;
  logic       shape_bad;
  logic       key_ok;

  assign off_w     = 8'(addr);
  assign shape_bad = (be != {BE_W{1'b1}}) || (addr[1:0] != 2'b00);
  assign key_ok    = (wdata == DATA_W'(SRST_KEY));

  always_comb begin
    case (off_w)
      OFF_SRST: sel = SEL_SRST;
      OFF_CTRL: sel = SEL_CTRL;
      OFF_SRC:  sel = SEL_SRC;
      OFF_DST:  sel = SEL_DST;
      OFF_LEN:  sel = SEL_LEN;
      OFF_STAT: sel = SEL_STAT;
      OFF_ISR:  sel = SEL_ISR;
      OFF_IER:  sel = SEL_IER;
      default:  sel = SEL_NONE;
    endcase
  end

  assign bad      = req && (shape_bad || (we && sel == SEL_SRST && !key_ok));
  assign wr_ok    = req && we && !bad;
  assign soft_hit = wr_ok && sel == SEL_SRST;

endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq #(
  parameter int unsigned N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clr,
  input  logic [N_EVT-1:0] evt,
  input  logic             tog_we,
  input  logic [N_EVT-1:0] tog_val,
  input  logic             ien_we,
  input  logic [N_EVT-1:0] ien_val,
  output logic [N_EVT-1:0] isr_q,
  output logic [N_EVT-1:0] ier_q,
  output logic             irq_o
);
  logic [N_EVT-1:0] isr_d;
  logic [N_EVT-1:0] ier_d;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    // toggle first, then event OR: a coincident event always wins
    assign isr_d[i] = (isr_q[i] ^ (tog_we & tog_val[i])) | evt[i];
    assign ier_d[i] = ien_we ? ien_val[i] : ier_q[i];

    always_ff @(posedge clk) begin
      if (rst || soft_clr) begin
        isr_q[i] <= 1'b0;
        ier_q[i] <= 1'b0;
      end else begin
        isr_q[i] <= isr_d[i];
        ier_q[i] <= ier_d[i];
      end
    end

    assert_evt_sets_R9 : assert property (@(posedge clk) disable iff (rst)
      (evt[i] && !soft_clr) |=> isr_q[i]);

    assert_toggle_R9 : assert property (@(posedge clk) disable iff (rst)
      (tog_we && tog_val[i] && !evt[i] && !soft_clr) |=> (isr_q[i] != $past(isr_q[i])));

    assert_set_wins_R10 : assert property (@(posedge clk) disable iff (rst)
      (tog_we && tog_val[i] && evt[i] && !soft_clr) |=> isr_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) irq_o <= 1'b0;
    else                 irq_o <= |(isr_d & ier_d);
  end

  assert_irq_level_R11 : assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(isr_q & ier_q)));

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dmareg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_ack,
  output logic                bus_err,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                cfg_src_inc,
  output logic                cfg_dst_inc,
  output logic [DATA_W-1:0]   cfg_src_addr,
  output logic [DATA_W-1:0]   cfg_dst_addr,
  output logic [DATA_W-1:0]   cfg_len,
  output logic                eng_start,
  output logic                eng_srst,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic [DATA_W-1:0]   live_src_addr,
  input  logic [DATA_W-1:0]   live_dst_addr,
  input  logic [DATA_W-1:0]   live_len,
  output logic                irq
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned PAD_W = DATA_W - 2;

  reg_sel_e         sel;
  logic             bad, wr_ok, soft_hit;
  logic             busy_q, berr_q;
  logic             busy_fall, prog_ok, start_ok;
  logic [N_EVT-1:0] isr_w, ier_w, evt_w;
  logic [DATA_W-1:0] rd_mux;

  dmareg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .be(bus_be), .wdata(bus_wdata),
    .sel(sel), .bad(bad), .wr_ok(wr_ok), .soft_hit(soft_hit)
  );

  assign busy_fall = busy_q && !eng_busy;
  assign prog_ok   = wr_ok && !eng_busy;
  assign start_ok  = prog_ok && sel == SEL_LEN;

  assign evt_w[EVT_DONE] = eng_done;
  assign evt_w[EVT_ERR]  = eng_err;

  dmareg_irq #(.N_EVT(N_EVT)) u_irq (
    .clk(clk), .rst(rst), .soft_clr(soft_hit), .evt(evt_w),
    .tog_we(wr_ok && sel == SEL_ISR), .tog_val(bus_wdata[N_EVT-1:0]),
    .ien_we(wr_ok && sel == SEL_IER), .ien_val(bus_wdata[N_EVT-1:0]),
    .isr_q(isr_w), .ier_q(ier_w), .irq_o(irq)
  );

  // programmable state, cleared by reset or the software key
  always_ff @(posedge clk) begin
    if (rst || soft_hit) begin
      cfg_src_inc  <= 1'b1;
      cfg_dst_inc  <= 1'b0;
      cfg_src_addr <= '0;
      cfg_dst_addr <= '0;
      cfg_len      <= '0;
      berr_q       <= 1'b0;
      busy_q       <= 1'b0;
      eng_start    <= 1'b0;
    end else begin
      busy_q    <= eng_busy;
      eng_start <= start_ok;
      if (wr_ok && sel == SEL_CTRL) begin
        cfg_src_inc <= bus_wdata[DATA_W-1];
        cfg_dst_inc <= bus_wdata[DATA_W-2];
      end
      if (busy_fall) begin
        cfg_src_addr <= live_src_addr;
        cfg_dst_addr <= live_dst_addr;
        cfg_len      <= live_len;
      end
      if (prog_ok && sel == SEL_SRC) cfg_src_addr <= bus_wdata;
      if (prog_ok && sel == SEL_DST) cfg_dst_addr <= bus_wdata;
      if (start_ok)                  cfg_len      <= bus_wdata;
      if (eng_err)       berr_q <= 1'b1;
      else if (start_ok) berr_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = {cfg_src_inc, cfg_dst_inc, {PAD_W{1'b0}}};
      SEL_SRC:  rd_mux = eng_busy ? live_src_addr : cfg_src_addr;
      SEL_DST:  rd_mux = eng_busy ? live_dst_addr : cfg_dst_addr;
      SEL_LEN:  rd_mux = eng_busy ? live_len : cfg_len;
      SEL_STAT: rd_mux = {eng_busy, berr_q, {PAD_W{1'b0}}};
      SEL_ISR:  rd_mux = DATA_W'(isr_w);
      SEL_IER:  rd_mux = DATA_W'(ier_w);
      default:  rd_mux = '0;
    endcase
  end

  // bus response path, only the hardware reset touches it
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
      eng_srst  <= 1'b0;
    end else begin
      bus_ack   <= bus_req;
      bus_err   <= bad;
      bus_rdata <= (bus_req && !bus_we && !bad) ? rd_mux : '0;
      eng_srst  <= soft_hit;
    end
  end

  assert_ack_follows_R2 : assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);

  assert_subword_err_R4 : assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_be != {BE_W{1'b1}}) |=> (bus_err && bus_rdata == '0));

  assert_start_idle_R6 : assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(!eng_busy && bus_req && bus_we));

  assert_berr_sticky_R8 : assert property (@(posedge clk) disable iff (rst)
    (eng_err && !soft_hit) |=> berr_q);

  assert_capture_R7 : assert property (@(posedge clk) disable iff (rst)
    (busy_fall && !soft_hit && !(prog_ok && sel == SEL_SRC)) |=> cfg_src_addr == $past(live_src_addr));

endmodule

// File: tb/dma_regfile_tb_top.sv
module dma_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we;
  logic [5:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic        cfg_src_inc, cfg_dst_inc;
  logic [31:0] cfg_src_addr, cfg_dst_addr, cfg_len;
  logic        eng_start, eng_srst;
  logic        eng_busy, eng_done, eng_err;
  logic [31:0] live_src_addr, live_dst_addr, live_len;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] r_data;
  logic        r_err, r_ack, r_start, r_srst;

  always #5 clk = ~clk;

  dma_regfile dut_i (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_len(cfg_len),
    .eng_start(eng_start), .eng_srst(eng_srst),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
    .live_src_addr(live_src_addr), .live_dst_addr(live_dst_addr), .live_len(live_len),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one-cycle request driven at the falling edge; response sampled one edge later
  task automatic xfer(input logic we, input logic [5:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic with_done);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    eng_done = with_done;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; eng_done = 1'b0;
    r_data = bus_rdata; r_err = bus_err; r_ack = bus_ack;
    r_start = eng_start; r_srst = eng_srst;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    xfer(1'b1, a, d, 4'hF, 1'b0);
  endtask

  task automatic rd(input logic [5:0] a);
    xfer(1'b0, a, 32'h0, 4'hF, 1'b0);
  endtask

  task automatic pulse_evt(input logic is_err);
    @(negedge clk);
    if (is_err) eng_err = 1'b1; else eng_done = 1'b1;
    @(negedge clk);
    eng_err = 1'b0; eng_done = 1'b0;
  endtask

  task automatic t_reset;
    rd(6'h04); chk("R1 ctrl", r_data, 32'h8000_0000);
    rd(6'h08); chk("R1 src", r_data, 32'h0);
    rd(6'h10); chk("R1 len", r_data, 32'h0);
    rd(6'h14); chk("R1 stat", r_data, 32'h0);
    rd(6'h2C); chk("R1 isr", r_data, 32'h0);
    rd(6'h30); chk("R1 ier", r_data, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(6'h08, 32'h0000_1000); chk("R2 ack", {31'h0, r_ack}, 32'h1);
    wr(6'h0C, 32'h0000_2000);
    wr(6'h04, 32'h4000_0000);
    rd(6'h08); chk("R2 src rd", r_data, 32'h0000_1000);
    rd(6'h0C); chk("R2 dst rd", r_data, 32'h0000_2000);
    rd(6'h04); chk("R2 ctrl rd", r_data, 32'h4000_0000);
    chk("R2 cfg inc", {30'h0, cfg_src_inc, cfg_dst_inc}, 32'h1);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18); chk("R2 reserved", r_data, 32'h0);
    rd(6'h00); chk("R2 srst reads 0", r_data, 32'h0);
    chk("R2 reserved write no effect", cfg_dst_addr, 32'h0000_2000);
  endtask

  task automatic t_subword;
    xfer(1'b1, 6'h08, 32'h0000_DEAD, 4'h3, 1'b0);
    chk("R4 half err", {31'h0, r_err}, 32'h1);
    chk("R4 no write", cfg_src_addr, 32'h0000_1000);
    xfer(1'b0, 6'h08, 32'h0, 4'h1, 1'b0);
    chk("R4 byte rd err", {31'h0, r_err}, 32'h1);
    chk("R4 byte rd data", r_data, 32'h0);
    xfer(1'b1, 6'h09, 32'h0000_BEEF, 4'hF, 1'b0);
    chk("R4 misaligned err", {31'h0, r_err}, 32'h1);
    chk("R4 misaligned no write", cfg_src_addr, 32'h0000_1000);
  endtask

  task automatic t_start;
    wr(6'h10, 32'h0000_0040);
    chk("R5 start pulse", {31'h0, r_start}, 32'h1);
    chk("R5 no err", {31'h0, r_err}, 32'h0);
    chk("R5 cfg len", cfg_len, 32'h0000_0040);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'h0, eng_start}, 32'h0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    live_src_addr = 32'h0000_1100; live_dst_addr = 32'h0000_2100; live_len = 32'h8;
    eng_busy = 1'b1;
    rd(6'h08); chk("R6 live src", r_data, 32'h0000_1100);
    rd(6'h10); chk("R6 live len", r_data, 32'h8);
    rd(6'h14); chk("R8 busy bit", r_data, 32'h8000_0000);
    wr(6'h08, 32'h0000_5555); chk("R6 src write ignored", cfg_src_addr, 32'h0000_1000);
    wr(6'h10, 32'h0000_0099);
    chk("R6 no start", {31'h0, r_start}, 32'h0);
    chk("R6 len kept", cfg_len, 32'h0000_0040);
    live_src_addr = 32'h0000_1140; live_dst_addr = 32'h0000_2140; live_len = 32'h0;
    @(negedge clk);
    eng_busy = 1'b0;
    @(negedge clk);
    chk("R7 src captured", cfg_src_addr, 32'h0000_1140);
    chk("R7 dst captured", cfg_dst_addr, 32'h0000_2140);
    rd(6'h10); chk("R7 len captured", r_data, 32'h0);
  endtask

  task automatic t_status;
    pulse_evt(1'b1);
    rd(6'h14); chk("R8 berr set", r_data, 32'h4000_0000);
    wr(6'h14, 32'h0000_0000);
    rd(6'h14); chk("R8 write no effect", r_data, 32'h4000_0000);
    wr(6'h10, 32'h0000_0010); chk("R8 start", {31'h0, r_start}, 32'h1);
    rd(6'h14); chk("R8 berr cleared", r_data, 32'h0);
  endtask

  task automatic t_isr;
    rd(6'h2C); chk("R9 err bit", r_data, 32'h2);
    wr(6'h2C, 32'h2);
    rd(6'h2C); chk("R9 toggle clears", r_data, 32'h0);
    pulse_evt(1'b0);
    rd(6'h2C); chk("R11 set while disabled", r_data, 32'h1);
    chk("R11 masked irq", {31'h0, irq}, 32'h0);
    wr(6'h30, 32'h1); chk("R11 irq on", {31'h0, irq}, 32'h1);
    wr(6'h2C, 32'h1); chk("R11 irq off", {31'h0, irq}, 32'h0);
    wr(6'h2C, 32'h2);
    rd(6'h2C); chk("R9 toggle sets", r_data, 32'h2);
    chk("R11 other bit masked", {31'h0, irq}, 32'h0);
    wr(6'h2C, 32'h2);
  endtask

  task automatic t_setwins;
    pulse_evt(1'b0);
    xfer(1'b1, 6'h2C, 32'h1, 4'hF, 1'b1);
    rd(6'h2C); chk("R10 set wins", r_data, 32'h1);
    chk("R10 irq held", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_srst;
    wr(6'h00, 32'h0000_0005);
    chk("R3 bad key err", {31'h0, r_err}, 32'h1);
    chk("R3 bad key no pulse", {31'h0, r_srst}, 32'h0);
    rd(6'h30); chk("R3 bad key no effect", r_data, 32'h1);
    wr(6'h00, 32'h0000_000A);
    chk("R3 pulse", {31'h0, r_srst}, 32'h1);
    chk("R3 no err", {31'h0, r_err}, 32'h0);
    chk("R3 irq cleared", {31'h0, irq}, 32'h0);
    rd(6'h04); chk("R3 ctrl default", r_data, 32'h8000_0000);
    rd(6'h08); chk("R3 src default", r_data, 32'h0);
    rd(6'h2C); chk("R3 isr default", r_data, 32'h0);
    rd(6'h30); chk("R3 ier default", r_data, 32'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    eng_busy = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
    live_src_addr = '0; live_dst_addr = '0; live_len = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_map;
    t_subword;
    t_start;
    t_busy;
    t_status;
    t_isr;
    t_setwins;
    t_srst;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule